// File: doc/BRIEF.md
# Serial Debug Port Connect Sequencer

This block brings a target's two-wire debug port out of reset, or out of its JTAG personality, and into serial-wire operation. A one-cycle `start` pulse launches a fixed bit stream on the debug clock and data pins. The stream is a long run of ones, the 16-bit select word 0xE79E sent least significant bit first, and a second run of ones. An optional 16-bit word 0xEDB6 and a third run of ones can follow. The stream ends with 16 low idle bits. Once the last idle bit has been clocked out, the block pulses `done`. One cycle later it pulses `id_rd_req` to ask the transaction engine for the first identification register read. It also presents the fixed header byte 0xA5 for that read.

Each bit lasts `2*HALF_DIV` system clocks. The debug clock is low for the first `HALF_DIV` clocks and high for the next `HALF_DIV`. The data pin changes only at the start of a bit, so the target sees stable data on every rising debug-clock edge. The optional word is selected by `extra_en`. This input is captured when a sequence starts, and the identification read is expected to succeed with the word left out.

Top module: `swd_connect_seq`

## Requirements
- R1: After reset, `dbg_clk`, `dbg_dat_oe`, `busy`, `done` and `id_rd_req` are all 0.
- R2: The first segment is `HIGH_RUN` bits (default 70, never fewer than 50) with `dbg_dat_o` = 1.
- R3: The second segment is the 16 bits of 0xE79E, bit 0 first.
- R4: The third segment is `HIGH_RUN` bits of 1.
- R5: When `extra_en` was 1 at start, the third segment is followed by the 16 bits of 0xEDB6 (bit 0 first) and then `HIGH_RUN` bits of 1. When `extra_en` was 0, neither is sent.
- R6: The last segment is 16 bits with `dbg_dat_o` = 0.
- R7: Each bit holds `dbg_clk` low for `HALF_DIV` clocks, then high for `HALF_DIV` clocks. `dbg_dat_o` never changes while `dbg_clk` is high, and `dbg_clk` stays 0 while no sequence runs.
- R8: `dbg_dat_oe` is 1 in every cycle of a running sequence and 0 otherwise.
- R9: `done` is a one-cycle pulse in the cycle after the last idle bit ends. `busy` is 0 from that cycle on.
- R10: `id_rd_req` is a one-cycle pulse in the cycle after `done`, and `id_hdr` is 0xA5.
- R11: `start` pulses and changes of `extra_en` while `busy` is 1 have no effect on the bit stream.
- R12: A `start` seen in the `done` cycle launches a new sequence, and `busy` is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, accepted only when idle |
| extra_en | input | 1 | Insert the optional word, captured at launch |
| dbg_clk | output | 1 | Debug clock to the target |
| dbg_dat_o | output | 1 | Debug data driven to the target |
| dbg_dat_oe | output | 1 | Output enable of the debug data pin |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| id_rd_req | output | 1 | One-cycle request for the identification read |
| id_hdr | output | 8 | Header byte for the identification read |

## Verification
Two events can land in the same clock: the end of one sequence, marked by `done`, and the acceptance of a new `start`. The bench provokes this by raising `start` in the exact cycle it observes `done`. It then expects `busy` high in the next cycle, and expects a second complete bit stream to follow, built with the newly applied `extra_en`. Random `start` pulses and random flips of `extra_en` during a running sequence are judged by comparing every sampled bit with the segment layout that the bench builds from the value of `extra_en` at launch.

// File: rtl/swd_conn_pkg.sv
package swd_conn_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RUN_A,
    PH_SWITCH,
    PH_RUN_B,
    PH_EXTRA,
    PH_RUN_C,
    PH_LOW
  } phase_e;

  localparam int WORD_BITS = 16;
  localparam int MIN_RUN   = 50;
endpackage

// File: rtl/swdc_bit_clock.sv
module swdc_bit_clock #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic line_clk,
  output logic bit_end
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ph_q, ph_d;
  logic          wrap;

  assign wrap = (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (!en) begin
      cnt_d = '0;
      ph_d  = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      ph_d  = ~ph_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign line_clk = ph_q;
  assign bit_end  = en & ph_q & wrap;

  a_r7_clk_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !line_clk);
  a_r7_bit_end_high_half: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |=> !line_clk);
endmodule

// File: rtl/swdc_bit_counter.sv
module swdc_bit_counter #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] len,
  output logic [W-1:0] idx,
  output logic         last
);
  logic [W-1:0] idx_q, idx_d;

  assign last = tick && (idx_q == len - 1'b1);

  always_comb begin
    idx_d = idx_q;
    if (clr || last) idx_d = '0;
    else if (tick)   idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign idx = idx_q;

  a_r2_idx_inside_segment: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (idx_q < len));
endmodule

// File: rtl/swd_connect_seq.sv
module swd_connect_seq
  import swd_conn_pkg::*;
#(
  parameter int          HIGH_RUN    = 70,
  parameter int          HALF_DIV    = 2,
  parameter logic [15:0] SWITCH_WORD = 16'hE79E,
  parameter logic [15:0] EXTRA_WORD  = 16'hEDB6,
  parameter logic [7:0]  ID_HEADER   = 8'hA5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       extra_en,
  output logic       dbg_clk,
  output logic       dbg_dat_o,
  output logic       dbg_dat_oe,
  output logic       busy,
  output logic       done,
  output logic       id_rd_req,
  output logic [7:0] id_hdr
);
  localparam int RUN_BITS = (HIGH_RUN < MIN_RUN) ? MIN_RUN : HIGH_RUN;
  localparam int MAX_SEG  = (RUN_BITS > WORD_BITS) ? RUN_BITS : WORD_BITS;
  localparam int IW       = $clog2(MAX_SEG + 1);

  phase_e        ph_q, ph_d;
  logic          ext_q, ext_d;
  logic          done_q, done_d;
  logic          req_q;
  logic          accept;
  logic          line_clk;
  logic          bit_end;
  logic          seg_last;
  logic [IW-1:0] idx;
  logic [IW-1:0] seg_len;
  logic [3:0]    wbit;

  assign accept = start && (ph_q == PH_IDLE);
  assign busy   = (ph_q != PH_IDLE);
  assign wbit   = idx[3:0];

  swdc_bit_clock #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (busy),
    .line_clk (line_clk),
    .bit_end  (bit_end)
  );

  swdc_bit_counter #(.W(IW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .tick  (bit_end),
    .len   (seg_len),
    .idx   (idx),
    .last  (seg_last)
  );

  always_comb begin
    unique case (ph_q)
      PH_RUN_A, PH_RUN_B, PH_RUN_C: seg_len = IW'(RUN_BITS);
      default:                      seg_len = IW'(WORD_BITS);
    endcase
  end

  always_comb begin
    ph_d   = ph_q;
    ext_d  = ext_q;
    done_d = 1'b0;
    if (accept) begin
      ph_d  = PH_RUN_A;
      ext_d = extra_en;
    end else if (seg_last) begin
      unique case (ph_q)
        PH_RUN_A:  ph_d = PH_SWITCH;
        PH_SWITCH: ph_d = PH_RUN_B;
        PH_RUN_B:  ph_d = ext_q ? PH_EXTRA : PH_LOW;
        PH_EXTRA:  ph_d = PH_RUN_C;
        PH_RUN_C:  ph_d = PH_LOW;
        PH_LOW: begin
          ph_d   = PH_IDLE;
          done_d = 1'b1;
        end
        default:   ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      ext_q  <= 1'b0;
      done_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      ext_q  <= ext_d;
      done_q <= done_d;
      req_q  <= done_q;
    end
  end

  always_comb begin
    unique case (ph_q)
      PH_SWITCH: dbg_dat_o = SWITCH_WORD[wbit];
      PH_EXTRA:  dbg_dat_o = EXTRA_WORD[wbit];
      PH_LOW:    dbg_dat_o = 1'b0;
      PH_IDLE:   dbg_dat_o = 1'b0;
      default:   dbg_dat_o = 1'b1;
    endcase
  end

  assign dbg_clk    = line_clk;
  assign dbg_dat_oe = busy;
  assign done       = done_q;
  assign id_rd_req  = req_q;
  assign id_hdr     = ID_HEADER;

  a_r7_dat_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_clk && $past(dbg_clk)) |-> $stable(dbg_dat_o));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !$past(start) || !busy || $past(ph_q == PH_IDLE) || $past(ph_q == PH_LOW));
  a_r10_req_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> id_rd_req);
  a_r11_start_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !seg_last) |=> (ph_q != PH_RUN_A) || (idx != '0) || $past(ph_q == PH_RUN_A));
  a_r12_start_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> busy);
  a_r8_oe_with_clock: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_clk |-> dbg_dat_oe);
endmodule

// File: tb/swd_connect_seq_test.sv
module swd_connect_seq_test;
  localparam int RUN  = 70;
  localparam int HALF = 2;

  logic clk, rst_n, start, extra_en;
  logic dbg_clk, dbg_dat_o, dbg_dat_oe, busy, done, id_rd_req;
  logic [7:0] id_hdr;

  int checks = 0;
  int fails  = 0;
  bit obs [0:511];
  int nobs;

  swd_connect_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .extra_en(extra_en),
    .dbg_clk(dbg_clk), .dbg_dat_o(dbg_dat_o), .dbg_dat_oe(dbg_dat_oe),
    .busy(busy), .done(done), .id_rd_req(id_rd_req), .id_hdr(id_hdr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_bit(input bit ext, input int i);
    int p = i;
    if (p < RUN) return 1'b1;
    p -= RUN;
    if (p < 16) return ((16'hE79E >> p) & 1) != 0;
    p -= 16;
    if (p < RUN) return 1'b1;
    p -= RUN;
    if (ext) begin
      if (p < 16) return ((16'hEDB6 >> p) & 1) != 0;
      p -= 16;
      if (p < RUN) return 1'b1;
      p -= RUN;
    end
    return 1'b0;
  endfunction

  function automatic int exp_len(input bit ext);
    return 2 * RUN + 32 + (ext ? (16 + RUN) : 0);
  endfunction

  task automatic cmp_seg(input string tag, input bit ext, input int off, input int len);
    int bad = 0;
    for (int i = off; i < off + len; i++)
      if (i >= nobs || obs[i] != exp_bit(ext, i)) bad++;
    chk(tag, bad, 0);
  endtask

  task automatic launch(input bit ext);
    @(negedge clk);
    start = 1'b1;
    extra_en = ext;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Watch one sequence; optionally start another in the done cycle.
  task automatic watch(input bit ext, input bit noisy, input bit chain, input bit next_ext);
    int  run_len = 0, bad_clk = 0, bad_dat = 0, bad_oe = 0, cyc = 0;
    bit  prevc = 1'b0, prevd = dbg_dat_o, early = 1'b0;
    nobs = 0;
    forever begin
      if (done) break;
      if (!busy) begin early = 1'b1; break; end
      if (!dbg_dat_oe) bad_oe++;
      if (dbg_clk && !prevc && nobs < 512) begin obs[nobs] = dbg_dat_o; nobs++; end
      if (dbg_clk == prevc && cyc != 0) run_len++;
      else begin
        if (cyc != 0 && run_len != HALF) bad_clk++;
        run_len = 1;
      end
      if (dbg_clk && prevc && dbg_dat_o != prevd) bad_dat++;
      prevc = dbg_clk;
      prevd = dbg_dat_o;
      start = noisy && ($urandom % 53 == 0);
      if (noisy && ($urandom % 29 == 0)) extra_en = ~extra_en;
      cyc++;
      if (cyc > 5000) begin early = 1'b1; break; end
      @(negedge clk);
    end
    start = 1'b0;
    chk("R9 sequence reached done", int'(early), 0);
    chk("R9 busy low in done cycle", int'(busy), 0);
    chk("R8 oe high while running", bad_oe, 0);
    chk("R7 half-bit lengths", bad_clk, 0);
    chk("R7 data steady while clock high", bad_dat, 0);
    chk(noisy ? "R11 bit count under noise" : "R5 bit count", nobs, exp_len(ext));
    cmp_seg("R2 first high run", ext, 0, RUN);
    cmp_seg("R3 switch word", ext, RUN, 16);
    cmp_seg("R4 second high run", ext, RUN + 16, RUN);
    if (ext) cmp_seg("R5 extra word and high run", ext, 2 * RUN + 16, 16 + RUN);
    cmp_seg("R6 low idle", ext, exp_len(ext) - 16, 16);
    if (noisy) cmp_seg("R11 stream intact under noise", ext, 0, exp_len(ext));
    if (chain) begin
      start = 1'b1;
      extra_en = next_ext;
    end
    @(negedge clk);
    start = 1'b0;
    chk("R10 id request after done", int'(id_rd_req), 1);
    chk("R9 done single cycle", int'(done), 0);
    chk("R10 header byte", int'(id_hdr), 8'hA5);
    if (chain) chk("R12 restart from done cycle", int'(busy), 1);
    else begin
      chk("R8 oe low when idle", int'(dbg_dat_oe), 0);
      chk("R7 clock low when idle", int'(dbg_clk), 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    start = 1'b0;
    extra_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 clock at reset", int'(dbg_clk), 0);
    chk("R1 oe at reset", int'(dbg_dat_oe), 0);
    chk("R1 busy at reset", int'(busy), 0);
    chk("R1 done at reset", int'(done), 0);
    chk("R1 request at reset", int'(id_rd_req), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    launch(1'b0);
    watch(1'b0, 1'b0, 1'b0, 1'b0);
    launch(1'b1);
    watch(1'b1, 1'b0, 1'b0, 1'b0);

    launch(1'b0);
    watch(1'b0, 1'b0, 1'b1, 1'b1);
    watch(1'b1, 1'b0, 1'b1, 1'b0);
    watch(1'b0, 1'b0, 1'b0, 1'b0);

    for (int k = 0; k < 6; k++) begin
      bit e = 1'($urandom % 2);
      repeat ($urandom % 7) @(negedge clk);
      launch(e);
      watch(e, 1'b1, 1'b0, 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule